// File: doc/BRIEF.md
# Two-Stage Timebase Watchdog

This block is a watchdog timer that software maps into its register space. A free-running timebase counter advances once per clock from reset. The watchdog counts only while two enable bits, kept in two separate control words, are both set. The expiry window is 2^N clocks. Each window boundary is the clock edge at which the low N bits of the timebase roll over from all ones to zero.

Expiry happens in two stages. The first boundary reached while armed raises a state flag and an interrupt. If software has not cleared that flag by the next boundary, the block drives a one-cycle reset pulse and latches a sticky reset-status flag. Software services the watchdog by writing a one to the state flag, which clears it. It stops the watchdog by clearing either enable.

A build-time option makes the first enable bit one-way, so that once set it can no longer be cleared by software.

Top module: `twostage_wdt`

## Requirements
- R1: After a synchronous active-low reset, both control words read 0, the timebase reads 0, and the interrupt and reset outputs are low.
- R2: Register map, decoded on address bits [3:2] with bits [1:0] ignored. Word 0 (0x0) holds reset-status at bit 3, state at bit 2 and enable A at bit 1, with bit 0 reading 0. Word 1 (0x4) holds enable B at bit 0. Word 2 (0x8) is the read-only timebase. Every unused bit reads 0. Writes to 0x8 or to 0xC change nothing.
- R3: The timebase increments by exactly one on every clock after reset, whatever the enable state, so two successive reads differ.
- R4: The watchdog is armed only while enable A and enable B are both 1. A boundary reached with either enable at 0 sets no flag, raises no interrupt and produces no reset.
- R5: A boundary reached while armed with the state flag clear sets the state flag. The interrupt is high exactly while the state flag is set and the block is armed.
- R6: A boundary reached while armed with the state flag set drives the reset output high for exactly the one clock after that edge, and sets reset-status at the same edge.
- R7: Writing word 0 with bit 2 at 1 clears the state flag, and writing it with bit 2 at 0 leaves the flag as it is. A clear that lands on the same edge as a boundary wins: no reset is produced, and the next boundary sets the flag again.
- R8: Writing word 0 with bit 3 at 1 clears reset-status, and writing it with bit 3 at 0 leaves it unchanged.
- R9: Clearing an enable drops the interrupt at once, and no reset follows. The state flag keeps its value.
- R10: With STICKY_EN=1, enable A stays 1 after writes of 0 once it has been set. With STICKY_EN=0 it follows each write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from reg_addr |
| wdt_irq | output | 1 | First-stage expiry interrupt, level high |
| wdt_rst | output | 1 | Second-stage expiry reset pulse, one clock wide |

## Verification
The expiry path is driven with four patterns. The first arms the block through one enable only, which shows whether arming needs both bits. The second arms it fully and leaves it unserviced, which separates the first-boundary flag from the second-boundary reset and measures the width of the reset pulse. The third services it between boundaries and again on the exact boundary edge, which shows whether the clear restarts the sequence and whether it beats a coinciding rollover. The fourth stops it with the flag already set, which shows that disarming holds off the reset without losing the flag. A table of register writes checks the map and the bits that are ignored before any expiry, and a second instance built with the one-way enable is compared against the default one.

// File: rtl/twostage_wdt_pkg.sv
// Package: shared register selector type and bit positions for the
// two-stage watchdog. Assumes 32-bit word registers at word offsets 0..2.
package twostage_wdt_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL0 = 2'd0,
        SEL_CTRL1 = 2'd1,
        SEL_TBASE = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    localparam int BIT_RSTFLAG = 3;
    localparam int BIT_STATE   = 2;
    localparam int BIT_ENA     = 1;
    localparam int BIT_ENB     = 0;
    localparam int WORD_LSB    = 2;

    typedef struct packed {
        logic clr_state;
        logic clr_rst;
    } w1c_t;

endpackage

// File: rtl/twostage_wdt_timebase.sv
// Free-running timebase counter. It counts every clock after reset and
// flags the cycle whose next edge rolls the low WIN_LOG2 bits to zero.
// Assumes 1 <= WIN_LOG2 <= CNT_W.
module twostage_wdt_timebase #(
    parameter int CNT_W    = 32,
    parameter int WIN_LOG2 = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt,
    output logic             roll
);

    localparam logic [WIN_LOG2-1:0] WIN_TOP = '1;

    // Advance the timebase by one on every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + CNT_W'(1);
    end

    // The next edge is a window boundary when the low bits are all ones.
    assign roll = (cnt[WIN_LOG2-1:0] == WIN_TOP);

endmodule

// File: rtl/twostage_wdt_expiry.sv
// Two-stage expiry logic. The first armed boundary sets the state flag,
// and a second boundary with the flag still set fires a one-clock reset
// pulse and latches reset-status. A clear of the state flag beats a
// boundary on the same edge.
module twostage_wdt_expiry
    import twostage_wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic roll,
    input  w1c_t w1c,
    output logic state_flag,
    output logic rst_flag,
    output logic rst_pulse,
    output logic irq
);

    logic boundary;
    logic fire;

    assign boundary = armed & roll;
    assign fire     = boundary & state_flag & ~w1c.clr_state;

    // State flag: cleared by software, set at the first armed boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)             state_flag <= 1'b0;
        else if (w1c.clr_state) state_flag <= 1'b0;
        else if (boundary)      state_flag <= 1'b1;
    end

    // Reset pulse: high for the single clock after a second-stage expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_pulse <= 1'b0;
        else        rst_pulse <= fire;
    end

    // Reset-status: set on expiry (which wins), cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n)           rst_flag <= 1'b0;
        else if (fire)        rst_flag <= 1'b1;
        else if (w1c.clr_rst) rst_flag <= 1'b0;
    end

    assign irq = state_flag & armed;

endmodule

// File: rtl/twostage_wdt_regs.sv
// Register decode and read mux. It holds the two enable bits, turns
// write-one-to-clear writes into strobes, and returns read data without
// a register stage. Address bits [1:0] are ignored, and any address bit
// above bit 3 must be zero for a hit.
module twostage_wdt_regs
    import twostage_wdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 32,
    parameter bit STICKY = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              state_flag,
    input  logic              rst_flag,
    output logic              en_a,
    output logic              en_b,
    output w1c_t              w1c,
    output logic [DATA_W-1:0] rdata
);

    logic     hi_zero;
    reg_sel_e sel;
    logic     wr_ctrl0;
    logic     wr_ctrl1;
    logic     unused_bits;

    generate
        if (ADDR_W > WORD_LSB + 2) begin : g_hi
            assign hi_zero = ~|addr[ADDR_W-1:WORD_LSB+2];
        end else begin : g_nohi
            assign hi_zero = 1'b1;
        end
    endgenerate

    // Turn the address into a register select.
    always_comb begin
        if (hi_zero) sel = reg_sel_e'(addr[WORD_LSB +: 2]);
        else         sel = SEL_NONE;
    end

    assign wr_ctrl0      = we & (sel == SEL_CTRL0);
    assign wr_ctrl1      = we & (sel == SEL_CTRL1);
    assign w1c.clr_state = wr_ctrl0 & wdata[BIT_STATE];
    assign w1c.clr_rst   = wr_ctrl0 & wdata[BIT_RSTFLAG];

    generate
        if (STICKY) begin : g_sticky
            // Enable A can be set but never cleared by software.
            always_ff @(posedge clk) begin
                if (!rst_n)        en_a <= 1'b0;
                else if (wr_ctrl0) en_a <= en_a | wdata[BIT_ENA];
            end
        end else begin : g_plain
            // Enable A follows every write to word 0.
            always_ff @(posedge clk) begin
                if (!rst_n)        en_a <= 1'b0;
                else if (wr_ctrl0) en_a <= wdata[BIT_ENA];
            end
        end
    endgenerate

    // Enable B follows every write to word 1.
    always_ff @(posedge clk) begin
        if (!rst_n)        en_b <= 1'b0;
        else if (wr_ctrl1) en_b <= wdata[BIT_ENB];
    end

    // Read mux with every unused bit at zero.
    always_comb begin
        rdata = '0;
        case (sel)
            SEL_CTRL0: begin
                rdata[BIT_RSTFLAG] = rst_flag;
                rdata[BIT_STATE]   = state_flag;
                rdata[BIT_ENA]     = en_a;
            end
            SEL_CTRL1: rdata[BIT_ENB] = en_b;
            SEL_TBASE: rdata[CNT_W-1:0] = cnt;
            default:   rdata = '0;
        endcase
    end

    assign unused_bits = ^{addr[WORD_LSB-1:0], wdata[DATA_W-1:BIT_RSTFLAG+1]};

endmodule

// File: rtl/twostage_wdt.sv
// Top of the two-stage watchdog. It wires the timebase, the register
// decode and the expiry logic together. Assumes CNT_W <= DATA_W and
// 1 <= WIN_LOG2 <= CNT_W. Reset is synchronous and active low.
module twostage_wdt
    import twostage_wdt_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int CNT_W     = 32,
    parameter int WIN_LOG2  = 16,
    parameter bit STICKY_EN = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              wdt_irq,
    output logic              wdt_rst
);

    logic [CNT_W-1:0] tb_cnt;
    logic             tb_roll;
    logic             en_a_w;
    logic             en_b_w;
    logic             state_w;
    logic             rstflag_w;
    w1c_t             w1c_w;

    twostage_wdt_timebase #(
        .CNT_W   (CNT_W),
        .WIN_LOG2(WIN_LOG2)
    ) u_tb (
        .clk  (clk),
        .rst_n(rst_n),
        .cnt  (tb_cnt),
        .roll (tb_roll)
    );

    twostage_wdt_regs #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W),
        .STICKY(STICKY_EN)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .cnt       (tb_cnt),
        .state_flag(state_w),
        .rst_flag  (rstflag_w),
        .en_a      (en_a_w),
        .en_b      (en_b_w),
        .w1c       (w1c_w),
        .rdata     (reg_rdata)
    );

    twostage_wdt_expiry u_exp (
        .clk       (clk),
        .rst_n     (rst_n),
        .armed     (en_a_w & en_b_w),
        .roll      (tb_roll),
        .w1c       (w1c_w),
        .state_flag(state_w),
        .rst_flag  (rstflag_w),
        .rst_pulse (wdt_rst),
        .irq       (wdt_irq)
    );

endmodule

// File: rtl/twostage_wdt_chk.sv
// Checker for the two-stage watchdog, attached to every instance of the
// top module by the bind statement at the end of this file.
module twostage_wdt_chk #(
    parameter int CNT_W  = 32,
    parameter bit STICKY = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt,
    input logic             en_a,
    input logic             en_b,
    input logic             state_flag,
    input logic             rst_flag,
    input logic             irq,
    input logic             rst_out
);

    // R3
    tb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cnt == $past(cnt) + CNT_W'(1));

    // R4
    irq_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (en_a && en_b));

    // R6
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out |=> !rst_out);

    // R6
    pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out |-> rst_flag);

    // R6
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out |-> ($past(state_flag) && $past(en_a) && $past(en_b)));

    // R9
    disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_a && en_b) |=> !rst_out);

    generate
        if (STICKY) begin : g_sticky_chk
            // R10
            sticky_ena_chk: assert property (@(posedge clk) disable iff (!rst_n)
                en_a |=> en_a);
        end
    endgenerate

endmodule

bind twostage_wdt twostage_wdt_chk #(
    .CNT_W (CNT_W),
    .STICKY(STICKY_EN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt       (tb_cnt),
    .en_a      (en_a_w),
    .en_b      (en_b_w),
    .state_flag(state_w),
    .rst_flag  (rstflag_w),
    .irq       (wdt_irq),
    .rst_out   (wdt_rst)
);

// File: tb/twostage_wdt_test.sv
module twostage_wdt_test;

    localparam int N    = 6;
    localparam int WMAX = (1 << N) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] rdata_once;
    logic        wdt_irq, wdt_rst, irq_once, rst_once;

    int checks = 0;
    int fails = 0;
    int rst_cnt = 0;
    int cyc = 0;
    logic rst_prev = 1'b0;
    logic [31:0] mdl = '0;

    always #4 clk = ~clk;

    twostage_wdt #(.WIN_LOG2(N), .STICKY_EN(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wdt_irq(wdt_irq), .wdt_rst(wdt_rst));

    twostage_wdt #(.WIN_LOG2(N), .STICKY_EN(1'b1)) uut_once (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_once),
        .wdt_irq(irq_once), .wdt_rst(rst_once));

    // Expected timebase: zero in reset, plus one per clock afterwards.
    always @(posedge clk) begin
        if (!rst_n) mdl <= '0;
        else        mdl <= mdl + 32'd1;
    end

    // Count reset pulses and catch any that last two sampled cycles.
    always @(negedge clk) begin
        if (wdt_rst) rst_cnt <= rst_cnt + 1;
        if (wdt_rst && rst_prev) begin
            fails <= fails + 1;
            $display("FAIL R6: reset pulse wider than one cycle (act 2 exp 1)");
        end
        rst_prev <= wdt_rst;
    end

    // Watchdog on the run itself.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 50000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish (act %0d exp <50000)", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act 0x%08h exp 0x%08h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_we = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic to_roll();
        @(negedge clk);
        while (mdl[N-1:0] != '0) @(negedge clk);
    endtask

    typedef struct packed {
        logic [3:0]  addr;
        logic [31:0] data;
        logic [31:0] exp0;
        logic [31:0] exp1;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{4'h0, 32'h0000_0002, 32'h2, 32'h0},
        '{4'h4, 32'h0000_0001, 32'h2, 32'h1},
        '{4'h8, 32'hFFFF_FFFF, 32'h2, 32'h1},
        '{4'hC, 32'h0000_0000, 32'h2, 32'h1},
        '{4'h0, 32'h0000_000E, 32'h2, 32'h1},
        '{4'h0, 32'h0000_0000, 32'h0, 32'h1},
        '{4'h4, 32'h0000_0000, 32'h0, 32'h0},
        '{4'h4, 32'hFFFF_FFFE, 32'h0, 32'h0},
        '{4'h0, 32'hFFFF_FFF0, 32'h0, 32'h0}
    };

    initial begin
        logic [31:0] v, v2;
        int base;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'h0, v); chk("R1 word0", v, 32'h0);
        rd(4'h4, v); chk("R1 word1", v, 32'h0);
        rd(4'h8, v); chk("R1 timebase", v, 32'h0);
        chk("R1 irq", {31'b0, wdt_irq}, 32'h0);
        chk("R1 rst", {31'b0, wdt_rst}, 32'h0);

        // R3 timebase steps every clock
        @(negedge clk);
        rd(4'h8, v);
        @(negedge clk);
        rd(4'h8, v2);
        chk("R3 step", v2 - v, 32'd1);
        chk("R3 value", v2, mdl);

        // R2 register map vectors
        foreach (VECS[i]) begin
            wr(VECS[i].addr, VECS[i].data);
            rd(4'h0, v); chk("R2 word0", v, VECS[i].exp0);
            rd(4'h4, v); chk("R2 word1", v, VECS[i].exp1);
            rd(4'h8, v); chk("R2 timebase", v, mdl);
        end

        // R4 one enable only: a boundary changes nothing
        wr(4'h0, 32'h2);
        to_roll();
        rd(4'h0, v); chk("R4 word0", v, 32'h2);
        chk("R4 irq", {31'b0, wdt_irq}, 32'h0);

        // R5 arm fully, first boundary sets the flag
        wr(4'h4, 32'h1);
        chk("R5 irq before", {31'b0, wdt_irq}, 32'h0);
        base = rst_cnt;
        to_roll();
        rd(4'h0, v); chk("R5 word0", v, 32'h6);
        chk("R5 irq", {31'b0, wdt_irq}, 32'h1);
        chk("R5 no rst", rst_cnt, base);

        // R6 second boundary: one-cycle reset and status
        to_roll();
        #1;
        chk("R6 rst high", {31'b0, wdt_rst}, 32'h1);
        rd(4'h0, v); chk("R6 word0", v, 32'hE);
        @(negedge clk);
        #1;
        chk("R6 rst low", {31'b0, wdt_rst}, 32'h0);
        chk("R6 count", rst_cnt, base + 1);

        // R8 clear of reset-status
        wr(4'h0, 32'h2);
        rd(4'h0, v); chk("R8 zero keeps", v, 32'hE);
        wr(4'h0, 32'hA);
        rd(4'h0, v); chk("R8 clear", v, 32'h6);

        // R7 keepalive between boundaries
        wr(4'h0, 32'h2);
        rd(4'h0, v); chk("R7 zero keeps", v, 32'h6);
        wr(4'h0, 32'h6);
        rd(4'h0, v); chk("R7 clear", v, 32'h2);
        chk("R7 irq low", {31'b0, wdt_irq}, 32'h0);
        base = rst_cnt;
        to_roll();
        #1;
        rd(4'h0, v); chk("R7 re-flag", v, 32'h6);
        chk("R7 no rst", rst_cnt, base);

        // R7 keepalive on the boundary edge
        @(negedge clk);
        while (mdl[N-1:0] != WMAX[N-1:0]) @(negedge clk);
        wr(4'h0, 32'h6);
        #1;
        rd(4'h0, v); chk("R7 same-edge", v, 32'h2);
        chk("R7 same-edge rst", {31'b0, wdt_rst}, 32'h0);
        to_roll();
        #1;
        rd(4'h0, v); chk("R7 restart", v, 32'h6);
        chk("R7 restart no rst", rst_cnt, base);

        // R9 stop with the flag set
        wr(4'h0, 32'h0);
        rd(4'h0, v); chk("R9 flag held", v, 32'h4);
        chk("R9 irq", {31'b0, wdt_irq}, 32'h0);
        wr(4'h4, 32'h0);
        to_roll();
        to_roll();
        #1;
        chk("R9 no rst", rst_cnt, base);
        rd(4'h0, v); chk("R9 word0", v, 32'h4);
        wr(4'h0, 32'h4);
        rd(4'h0, v); chk("R9 cleared", v, 32'h0);

        // R10 one-way enable A on the second instance
        wr(4'h0, 32'h2);
        wr(4'h0, 32'h0);
        reg_addr = 4'h0;
        #1;
        chk("R10 sticky", rdata_once & 32'h2, 32'h2);
        chk("R10 plain", reg_rdata & 32'h2, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule